// File: doc/BRIEF.md
# Dual-Path Remote Address Failover Remapper

This block sits on the outgoing memory request path of one host in a rack whose hosts share a global address pool. Each remote host owns a 32 GB slot and can be reached through two aliases of that slot. The primary alias goes through one bridge port. The secondary alias sits exactly 1 TB higher and goes through a separate port. The block keeps one path bit per remote host. While a host's bit selects the secondary path, any request that lands in that host's primary alias is moved up by 1 TB. All other requests leave the block exactly as they entered.

Another agent detects the fault and delivers the notice. A failover notice names a host index and moves that host onto its secondary alias. A restore notice names a host index and moves that host back to its primary alias. Address rewriting is purely combinational. The path bits change on the clock edge that follows a notice, so the block completes any per-host update in a single cycle, well inside a 1 µs budget. An index beyond the supported host count changes nothing and raises a one-cycle error flag.

Top module: `dual_path_remapper`

## Requirements
- R1: The primary alias of remote host k (k = 0 .. NUM_HOSTS-1, host index field 4 bits wide) is the address interval [64 GB + k·32 GB, 64 GB + (k+1)·32 GB). Both ends of this interval are decoded exactly.
- R2: After reset, every host is on its primary path and the error flag is low, so every address passes through unchanged.
- R3: An address outside every primary alias passes through unchanged. This covers the local space below 64 GB, addresses at or above the end of the last alias, and the secondary aliases themselves.
- R4: A failover notice with an in-range index k takes effect from the next clock edge. From then on, every address in host k's primary alias leaves the block increased by exactly 2^40 (1 TB).
- R5: A request into the primary alias of a host that is still on its primary path passes through unchanged, even when other hosts have failed over.
- R6: A restore notice with an in-range index k returns host k to its primary path from the next clock edge.
- R7: A request presented in the same cycle as a notice is mapped with the path bits held before that notice.
- R8: If a failover notice and a restore notice name the same host in the same cycle, the failover wins and the host ends up on its secondary path.
- R9: A failover or restore notice whose index is 8 or more (at the default 8 hosts) changes no path bit. In the following cycle it raises the error flag for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_addr_i | input | 48 | Outgoing request address before remapping |
| req_addr_o | output | 48 | Request address after remapping (combinational) |
| fail_valid_i | input | 1 | Failover notice strobe |
| fail_host_i | input | 4 | Host index carried by the failover notice |
| restore_valid_i | input | 1 | Restore notice strobe |
| restore_host_i | input | 4 | Host index carried by the restore notice |
| idx_err_o | output | 1 | One-cycle flag, raised in the cycle after a notice with an out-of-range index |

## Verification
Two pairs of functions can coincide in one cycle. A request can arrive together with a notice for the host it targets. A failover and a restore can also name the same host at once. The bench provokes the first pair by presenting a request into host k's alias in the very cycle that its failover or restore notice is driven. It expects the old mapping in that cycle and the new mapping one cycle later. It provokes the second pair by issuing both notices for one host together, and then judges the outcome through the next request to that host's alias, which must come out 1 TB higher.

// File: rtl/remap_pkg.sv
package remap_pkg;

  // Path selected for one remote host.
  typedef enum logic {
    PATH_PRIMARY   = 1'b0,
    PATH_SECONDARY = 1'b1
  } path_e;

  localparam int unsigned DEF_ADDR_W    = 48;
  localparam int unsigned DEF_NUM_HOSTS = 8;
  localparam int unsigned DEF_IDX_W     = 4;
  localparam int unsigned DEF_SLOT_LOG2 = 35;  // 32 GB slot
  localparam int unsigned DEF_BASE_LOG2 = 36;  // first alias at 64 GB
  localparam int unsigned DEF_ALT_LOG2  = 40;  // secondary alias offset 1 TB

endpackage

// File: rtl/alias_window_decode.sv
module alias_window_decode #(
  parameter int unsigned ADDR_W    = remap_pkg::DEF_ADDR_W,
  parameter int unsigned NUM_HOSTS = remap_pkg::DEF_NUM_HOSTS,
  parameter int unsigned SLOT_LOG2 = remap_pkg::DEF_SLOT_LOG2,
  parameter int unsigned BASE_LOG2 = remap_pkg::DEF_BASE_LOG2,
  parameter int unsigned SEL_W     = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  host_o
);

  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(64'd1) << BASE_LOG2;
  localparam logic [ADDR_W-1:0] SLOT_SZ  = ADDR_W'(64'd1) << SLOT_LOG2;
  localparam logic [ADDR_W-1:0] WIN_END  = WIN_BASE + (ADDR_W'(NUM_HOSTS) << SLOT_LOG2);

  // Lower bound of slot k inside the alias window.
  function automatic logic [ADDR_W-1:0] slot_floor(input int unsigned k);
    return WIN_BASE + (ADDR_W'(k) * SLOT_SZ);
  endfunction

  always_comb begin
    hit_o = (addr_i >= WIN_BASE) && (addr_i < WIN_END);
  end

  // Highest slot whose floor lies at or below the address.
  always_comb begin
    host_o = '0;
    for (int unsigned k = 1; k < NUM_HOSTS; k++) begin
      if (addr_i >= slot_floor(k)) host_o = SEL_W'(k);
    end
  end

endmodule

// File: rtl/path_state_table.sv
module path_state_table #(
  parameter int unsigned NUM_HOSTS = remap_pkg::DEF_NUM_HOSTS,
  parameter int unsigned IDX_W     = remap_pkg::DEF_IDX_W,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fail_valid_i,
  input  logic [IDX_W-1:0]     fail_host_i,
  input  logic                 restore_valid_i,
  input  logic [IDX_W-1:0]     restore_host_i,
  output logic [NUM_HOSTS-1:0] path_sec_o,
  output logic                 idx_err_o
);

  import remap_pkg::*;

  logic fail_in_rng;
  logic rest_in_rng;
  logic err_d;
  logic err_q;

  always_comb begin
    fail_in_rng = 32'(fail_host_i) < NUM_HOSTS;
    rest_in_rng = 32'(restore_host_i) < NUM_HOSTS;
    err_d = (fail_valid_i && !fail_in_rng) || (restore_valid_i && !rest_in_rng);
  end

  for (genvar k = 0; k < NUM_HOSTS; k++) begin : g_host
    logic  set_k;
    logic  clr_k;
    logic  en_k;
    path_e path_d;
    path_e path_q;

    // Failover takes priority over a restore for the same host.
    always_comb begin
      set_k  = fail_valid_i    && (fail_host_i    == IDX_W'(k));
      clr_k  = restore_valid_i && (restore_host_i == IDX_W'(k));
      en_k   = set_k || clr_k;
      path_d = set_k ? PATH_SECONDARY : PATH_PRIMARY;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        path_q <= PATH_PRIMARY;
      end else if (en_k) begin
        path_q <= path_d;
      end
    end

    assign path_sec_o[k] = (path_q == PATH_SECONDARY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign idx_err_o = err_q;

  AST_FAIL_SWITCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_valid_i && fail_in_rng) |=> path_sec_o[$past(fail_host_i[SEL_W-1:0])]); // R4
  AST_RESTORE_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_valid_i && rest_in_rng && !(fail_valid_i && fail_host_i == restore_host_i))
    |=> !path_sec_o[$past(restore_host_i[SEL_W-1:0])]); // R6
  AST_TIE_FAILOVER_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_valid_i && restore_valid_i && fail_in_rng && fail_host_i == restore_host_i)
    |=> path_sec_o[$past(fail_host_i[SEL_W-1:0])]); // R8
  AST_BAD_INDEX_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_valid_i && !fail_in_rng) |=> idx_err_o); // R9
  AST_BAD_INDEX_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!fail_valid_i || !fail_in_rng) && (!restore_valid_i || !rest_in_rng))
    |=> $stable(path_sec_o)); // R9

endmodule

// File: rtl/alias_rewrite.sv
module alias_rewrite #(
  parameter int unsigned ADDR_W    = remap_pkg::DEF_ADDR_W,
  parameter int unsigned NUM_HOSTS = remap_pkg::DEF_NUM_HOSTS,
  parameter int unsigned ALT_LOG2  = remap_pkg::DEF_ALT_LOG2,
  parameter int unsigned SEL_W     = 3
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 hit_i,
  input  logic [SEL_W-1:0]     host_i,
  input  logic [NUM_HOSTS-1:0] path_sec_i,
  output logic [ADDR_W-1:0]    addr_o
);

  localparam logic [ADDR_W-1:0] ALT_OFS = ADDR_W'(64'd1) << ALT_LOG2;

  logic use_alt;

  always_comb begin
    use_alt = hit_i && path_sec_i[host_i];
    addr_o  = use_alt ? (addr_i + ALT_OFS) : addr_i;
  end

endmodule

// File: rtl/dual_path_remapper.sv
module dual_path_remapper #(
  parameter int unsigned ADDR_W    = remap_pkg::DEF_ADDR_W,
  parameter int unsigned NUM_HOSTS = remap_pkg::DEF_NUM_HOSTS,
  parameter int unsigned IDX_W     = remap_pkg::DEF_IDX_W,
  parameter int unsigned SLOT_LOG2 = remap_pkg::DEF_SLOT_LOG2,
  parameter int unsigned BASE_LOG2 = remap_pkg::DEF_BASE_LOG2,
  parameter int unsigned ALT_LOG2  = remap_pkg::DEF_ALT_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              fail_valid_i,
  input  logic [IDX_W-1:0]  fail_host_i,
  input  logic              restore_valid_i,
  input  logic [IDX_W-1:0]  restore_host_i,
  output logic              idx_err_o
);

  localparam int unsigned SEL_W = (NUM_HOSTS > 1) ? $clog2(NUM_HOSTS) : 1;
  localparam logic [ADDR_W-1:0] ALT_OFS = ADDR_W'(64'd1) << ALT_LOG2;

  // Reset synchronizer: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  logic                 win_hit;
  logic [SEL_W-1:0]     win_host;
  logic [NUM_HOSTS-1:0] path_sec;

  alias_window_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_HOSTS(NUM_HOSTS),
    .SLOT_LOG2(SLOT_LOG2),
    .BASE_LOG2(BASE_LOG2),
    .SEL_W    (SEL_W)
  ) u_decode (
    .addr_i(req_addr_i),
    .hit_o (win_hit),
    .host_o(win_host)
  );

  path_state_table #(
    .NUM_HOSTS(NUM_HOSTS),
    .IDX_W    (IDX_W),
    .SEL_W    (SEL_W)
  ) u_table (
    .clk_i          (clk_i),
    .rst_ni         (rst_sync_n),
    .fail_valid_i   (fail_valid_i),
    .fail_host_i    (fail_host_i),
    .restore_valid_i(restore_valid_i),
    .restore_host_i (restore_host_i),
    .path_sec_o     (path_sec),
    .idx_err_o      (idx_err_o)
  );

  alias_rewrite #(
    .ADDR_W   (ADDR_W),
    .NUM_HOSTS(NUM_HOSTS),
    .ALT_LOG2 (ALT_LOG2),
    .SEL_W    (SEL_W)
  ) u_rewrite (
    .addr_i    (req_addr_i),
    .hit_i     (win_hit),
    .host_i    (win_host),
    .path_sec_i(path_sec),
    .addr_o    (req_addr_o)
  );

  AST_OUTSIDE_PASSES: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !win_hit |-> (req_addr_o == req_addr_i)); // R3
  AST_SHIFT_IS_ALT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (req_addr_o != req_addr_i) |-> (req_addr_o - req_addr_i == ALT_OFS)); // R4
  AST_PRIMARY_PASSES: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (win_hit && !path_sec[win_host]) |-> (req_addr_o == req_addr_i)); // R5
  AST_RESET_CLEAN: assert property (@(posedge clk_i)
    (rst_sync_n && !$past(rst_sync_n)) |-> (path_sec == '0 && !idx_err_o)); // R2

endmodule

// File: tb/dual_path_remapper_bench.sv
`timescale 1ns/1ps
module dual_path_remapper_bench;

  localparam int NH = 8;
  localparam logic [47:0] GB   = 48'd1 << 30;
  localparam logic [47:0] WBAS = 48'd64 << 30;
  localparam logic [47:0] SLOT = 48'd32 << 30;
  localparam logic [47:0] WEND = WBAS + 48'(NH) * SLOT;
  localparam logic [47:0] TB1  = 48'd1 << 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] a_in;
  logic [47:0] a_out;
  logic        fv, rv;
  logic [3:0]  fh, rh;
  logic        err;

  always #2.5 clk = ~clk;

  dual_path_remapper u_dual_path_remapper (
    .clk_i(clk), .rst_ni(rst_n), .req_addr_i(a_in), .req_addr_o(a_out),
    .fail_valid_i(fv), .fail_host_i(fh), .restore_valid_i(rv),
    .restore_host_i(rh), .idx_err_o(err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model
  bit m_sec [NH];
  bit m_err;

  logic [47:0] q_addr[$];
  logic        q_err[$];
  string       q_tag[$];

  function automatic logic [47:0] model_addr(input logic [47:0] a);
    if (a >= WBAS && a < WEND) begin
      int k = int'((a - WBAS) / SLOT);
      if (m_sec[k]) return a + TB1;
    end
    return a;
  endfunction

  function automatic logic [47:0] prim(input int k, input logic [47:0] ofs);
    return WBAS + 48'(k) * SLOT + ofs;
  endfunction

  // Driver: one cycle of stimulus, expected result pushed to scoreboard
  task automatic cyc(input logic [47:0] a, input bit f, input int fi,
                     input bit r, input int ri, input string tag);
    bit bad;
    @(posedge clk);
    #1;
    a_in = a; fv = f; fh = 4'(fi); rv = r; rh = 4'(ri);
    q_addr.push_back(model_addr(a));
    q_err.push_back(m_err);
    q_tag.push_back(tag);
    bad = (f && fi >= NH) || (r && ri >= NH);
    if (r && ri < NH) m_sec[ri] = 1'b0;
    if (f && fi < NH) m_sec[fi] = 1'b1;
    m_err = bad;
  endtask

  task automatic req(input logic [47:0] a, input string tag);
    cyc(a, 1'b0, 0, 1'b0, 0, tag);
  endtask

  // Monitor: compares outputs mid-cycle
  always @(posedge clk) begin
    #3;
    if (q_addr.size() > 0) begin
      logic [47:0] ea;
      logic        ee;
      string       t;
      ea = q_addr.pop_front();
      ee = q_err.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (a_out !== ea) begin
        errors++;
        $display("FAIL %s addr in=%h actual=%h expected=%h", t, a_in, a_out, ea);
      end
      checks++;
      if (err !== ee) begin
        errors++;
        $display("FAIL %s err actual=%b expected=%b", t, err, ee);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NH; k++) m_sec[k] = 1'b0;
    m_err = 1'b0;
    rst_n = 1'b0; a_in = '0; fv = 0; rv = 0; fh = '0; rh = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: every host on primary after reset
    for (int k = 0; k < NH; k++) req(prim(k, 48'h123), "R2 reset primary");

    // R1 / R3: window edges
    req(WBAS - 1, "R3 below window");
    req(WBAS, "R1 first byte host0");
    req(WEND - 1, "R1 last byte host7");
    req(WEND, "R3 past window");
    req(48'd0, "R3 local zero");
    req(TB1 + WBAS, "R3 secondary alias");

    // R7 then R4 / R5: failover host 2
    cyc(prim(2, 48'h40), 1'b1, 2, 1'b0, 0, "R7 same-cycle failover");
    req(prim(2, 48'h40), "R4 host2 moved");
    req(prim(2, 0), "R4 host2 low edge");
    req(prim(2, SLOT - 1), "R4 host2 high edge");
    req(prim(3, 0), "R5 host3 untouched");
    req(prim(1, SLOT - 1), "R5 host1 untouched");
    req(TB1 + prim(2, 48'h40), "R3 secondary not moved twice");

    // R4 on last host, end of window still outside
    cyc(prim(7, 0), 1'b1, 7, 1'b0, 0, "R7 host7 old map");
    req(WEND - 1, "R4 host7 last byte");
    req(WEND, "R3 past window after failover");

    // R6 restore host 2, R7 same cycle keeps secondary
    cyc(prim(2, 48'h80), 1'b0, 0, 1'b1, 2, "R7 same-cycle restore");
    req(prim(2, 48'h80), "R6 host2 back to primary");

    // R8 tie on host 5
    cyc(prim(5, 48'h10), 1'b1, 5, 1'b1, 5, "R8 tie cycle old map");
    req(prim(5, 48'h10), "R8 failover wins");
    cyc(prim(5, 48'h10), 1'b0, 0, 1'b1, 5, "R6 restore host5 same cycle");
    req(prim(5, 48'h10), "R6 host5 primary");

    // R9 out-of-range indices
    cyc(prim(0, 48'h8), 1'b1, 9, 1'b0, 0, "R9 bad failover cycle");
    req(prim(0, 48'h8), "R9 err raised host0 unchanged");
    req(prim(1, 48'h8), "R9 err drops after one cycle");
    for (int k = 0; k < NH; k++) req(prim(k, 48'h4), "R9 state untouched");
    cyc(prim(7, 48'h4), 1'b0, 0, 1'b1, 12, "R9 bad restore cycle");
    req(prim(7, 48'h4), "R9 restore err host7 kept");
    cyc(prim(3, 0), 1'b1, 15, 1'b1, 3, "R9 bad failover with good restore");
    req(prim(3, 0), "R9 err with good restore");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      int sel = int'($urandom_range(0, 9));
      logic [47:0] a = WBAS - SLOT + 48'($urandom_range(0, 2 * NH + 3)) * (SLOT / 2)
                       + 48'($urandom_range(0, 255));
      bit f = ($urandom_range(0, 3) == 0);
      bit r = ($urandom_range(0, 3) == 0);
      cyc(a, f, sel, r, int'($urandom_range(0, 9)), "R4 R5 R6 mixed traffic");
    end
    req(48'd0, "R3 drain");
    repeat (3) @(posedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule